// File: doc/BRIEF.md
# Banked Bit-Addressable Internal Data Memory

This block is the on-chip data store of an 8-bit controller. It offers four ways into the same storage: a byte port with an 8-bit address, a register port that names one of eight working registers in the currently selected bank, a bit port that reads or rewrites a single flag, and a stack port driven by an 8-bit stack pointer. All four read combinationally. Writes take effect at the next rising clock edge.

The register port is an alias into the low 32 bytes of RAM. A 2-bit bank select chooses which group of eight bytes the register index lands in. Bit addresses below 0x80 reach a 16-byte flag region of RAM. Bit addresses from 0x80 upward reach a small file of special-function register bytes: only those whose byte address ends in hex 0 or 8 are held here. The stack uses the whole 256-byte RAM. The byte port reaches only its lower half, because byte addresses from 0x80 upward decode to the special-function space.

Top module: `idm_bank_mem`

## Requirements
- R1: After reset the stack pointer reads 0x07, and every RAM byte and every held special-function byte reads 0x00.
- R2: Working register n (0..7) of bank b (0..3) is RAM byte 8*b+n. A write through either the register port or the byte port is seen through the other one.
- R3: A change of the bank select acts at once. A register read or write in the same cycle as the change already uses the new bank.
- R4: Bit address k in 0x00..0x7F names bit (k mod 8) of RAM byte 0x20 + (k div 8).
- R5: Bit address k in 0x80..0xFF names bit (k mod 8) of the special-function byte at address k with its low three bits cleared. Byte addresses 0x80..0xFF whose low three bits are zero hold a stored byte. The other byte addresses in that range read 0x00, and writes to them are ignored.
- R6: A bit write changes only the named bit in one clock edge. The other seven bits of that byte keep their values.
- R7: When several ports write the same RAM byte at one edge, the byte port wins, then the register port, then the bit port, then a stack push. A byte write and a bit write to the same special-function byte leave the byte value.
- R8: A push first increments the stack pointer and then writes the push data at the new pointer. The stack read data always shows the RAM byte at the current pointer.
- R9: A pop decrements the stack pointer by one. The byte it removes is the stack read data shown before that edge. When push and pop are raised together, only the push is done.
- R10: The stack pointer is 8 bits wide and wraps modulo 256. Starting from reset, 248 pushes fill RAM bytes 0x08..0xFF. Bytes at 0x80 and above are stack storage only and do not alias the special-function bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Working-register bank in use |
| byte_addr | input | 8 | Byte port address |
| byte_wr | input | 1 | Byte port write enable |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data |
| reg_idx | input | 3 | Working-register index |
| reg_wr | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| bit_addr | input | 8 | Bit port address |
| bit_wr | input | 1 | Bit write strobe |
| bit_wdata | input | 1 | Bit value to write |
| bit_rdata | output | 1 | Bit read data |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_wdata | input | 8 | Push data |
| stk_rdata | output | 8 | Byte at the stack pointer |
| sp_out | output | 8 | Current stack pointer |

## Verification
The address decoder is tried with the same register index in all four banks. A difference there shows whether the bank bits reach the right byte or fold onto one bank. Bit accesses use both ends of the flag region and a mix of held and unheld special-function addresses, which separates RAM from SFR decoding and bit position from byte offset. Bit writes go into bytes preset to patterns such as 0xA5 and 0xFF, which shows any read-modify-write that disturbs neighbouring bits. Same-edge collisions, a full 248-deep push and pop, and a pointer wrap past 0xFF test port priority and stack address arithmetic.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int BYTE_W     = 8;
  localparam int BANK_W     = 2;
  localparam int IDX_W      = 3;
  localparam int SFR_SLOTS  = 16;
  localparam int SLOT_W     = $clog2(SFR_SLOTS);
  localparam logic [7:0] FLAG_BASE = 8'h20;

  // byte address of working register idx in bank
  function automatic logic [7:0] reg_home(input logic [BANK_W-1:0] bank,
                                          input logic [IDX_W-1:0] idx);
    return {3'b000, bank, idx};
  endfunction

  // byte that holds bit address k
  function automatic logic [7:0] bit_home(input logic [7:0] k);
    if (k[7]) return {k[7:3], 3'b000};
    else      return FLAG_BASE | {4'b0000, k[6:3]};
  endfunction

  // byte address in SFR space that has storage here
  function automatic logic sfr_held(input logic [7:0] a);
    return a[7] && (a[2:0] == 3'b000);
  endfunction

  function automatic logic [SLOT_W-1:0] sfr_slot(input logic [7:0] a);
    return a[6:3];
  endfunction

  // replace one bit of a byte
  function automatic logic [7:0] put_bit(input logic [7:0] old,
                                         input logic [2:0] pos,
                                         input logic val);
    logic [7:0] r;
    r = old;
    r[pos] = val;
    return r;
  endfunction
endpackage

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH = 256,
  parameter int NRD   = 4,
  parameter int NWR   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [7:0]    rd_data [NRD],
  input  logic [NWR-1:0] wr_en,
  input  logic [AW-1:0] wr_addr [NWR],
  input  logic [7:0]    wr_data [NWR]
);
  logic [7:0] mem [DEPTH];

  // higher port index is applied later and so wins a collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/idm_bit_decode.sv
module idm_bit_decode
  import idm_pkg::*;
(
  input  logic [7:0]        bit_addr,
  output logic              in_sfr,
  output logic [7:0]        home,
  output logic [SLOT_W-1:0] slot,
  output logic [2:0]        pos
);
  always_comb begin
    in_sfr = bit_addr[7];
    home   = bit_home(bit_addr);
    slot   = sfr_slot(home);
    pos    = bit_addr[2:0];
  end
endmodule

// File: rtl/idm_stack_ptr.sv
module idm_stack_ptr #(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  output logic [7:0] sp,
  output logic [7:0] push_addr,
  output logic       push_ev,
  output logic       pop_ev
);
  assign push_ev   = push;
  assign pop_ev    = pop && !push;
  assign push_addr = sp + 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= SP_RESET;
    else if (push_ev) sp <= push_addr;
    else if (pop_ev)  sp <= sp - 8'd1;
  end
endmodule

// File: rtl/idm_bank_mem.sv
module idm_bank_mem
  import idm_pkg::*;
#(
  parameter int         RAM_BYTES = 256,
  parameter logic [7:0] SP_RESET  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_sel,
  input  logic [7:0] byte_addr,
  input  logic       byte_wr,
  input  logic [7:0] byte_wdata,
  output logic [7:0] byte_rdata,
  input  logic [2:0] reg_idx,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] bit_addr,
  input  logic       bit_wr,
  input  logic       bit_wdata,
  output logic       bit_rdata,
  input  logic       stk_push,
  input  logic       stk_pop,
  input  logic [7:0] stk_wdata,
  output logic [7:0] stk_rdata,
  output logic [7:0] sp_out
);
  localparam int AW = $clog2(RAM_BYTES);
  // RAM port indices, lowest priority first
  localparam int WP_STK = 0, WP_BIT = 1, WP_REG = 2, WP_BYTE = 3, NWR = 4;
  localparam int RP_BYTE = 0, RP_REG = 1, RP_BIT = 2, RP_STK = 3, NRD = 4;

  // decode
  logic              bit_in_sfr;
  logic [7:0]        bit_byte;
  logic [SLOT_W-1:0] bit_slot;
  logic [2:0]        bit_pos;
  logic [7:0]        reg_byte;
  logic              byte_in_ram, byte_sfr_ok;

  idm_bit_decode u_bdec (
    .bit_addr(bit_addr), .in_sfr(bit_in_sfr), .home(bit_byte),
    .slot(bit_slot), .pos(bit_pos)
  );

  assign reg_byte    = reg_home(bank_sel, reg_idx);
  assign byte_in_ram = !byte_addr[7];
  assign byte_sfr_ok = sfr_held(byte_addr);

  // stack pointer
  logic [7:0] push_addr;
  logic       push_ev, pop_ev;

  idm_stack_ptr #(.SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .sp(sp_out), .push_addr(push_addr), .push_ev(push_ev), .pop_ev(pop_ev)
  );

  // RAM
  logic [AW-1:0]  ram_raddr [NRD];
  logic [7:0]     ram_rdata [NRD];
  logic [NWR-1:0] ram_we;
  logic [AW-1:0]  ram_waddr [NWR];
  logic [7:0]     ram_wdata [NWR];

  always_comb begin
    ram_raddr[RP_BYTE] = AW'(byte_addr);
    ram_raddr[RP_REG]  = AW'(reg_byte);
    ram_raddr[RP_BIT]  = AW'(bit_byte);
    ram_raddr[RP_STK]  = AW'(sp_out);

    ram_we[WP_STK]     = push_ev;
    ram_waddr[WP_STK]  = AW'(push_addr);
    ram_wdata[WP_STK]  = stk_wdata;

    ram_we[WP_BIT]     = bit_wr && !bit_in_sfr;
    ram_waddr[WP_BIT]  = AW'(bit_byte);
    ram_wdata[WP_BIT]  = put_bit(ram_rdata[RP_BIT], bit_pos, bit_wdata);

    ram_we[WP_REG]     = reg_wr;
    ram_waddr[WP_REG]  = AW'(reg_byte);
    ram_wdata[WP_REG]  = reg_wdata;

    ram_we[WP_BYTE]    = byte_wr && byte_in_ram;
    ram_waddr[WP_BYTE] = AW'(byte_addr);
    ram_wdata[WP_BYTE] = byte_wdata;
  end

  idm_ram #(.DEPTH(RAM_BYTES), .NRD(NRD), .NWR(NWR)) u_ram (
    .clk(clk), .rst_n(rst_n), .rd_addr(ram_raddr), .rd_data(ram_rdata),
    .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata)
  );

  // bit-addressable SFR bytes; byte port (index 1) beats bit port
  logic [SLOT_W-1:0] sfr_raddr [2];
  logic [7:0]        sfr_rdata [2];
  logic [1:0]        sfr_we;
  logic [SLOT_W-1:0] sfr_waddr [2];
  logic [7:0]        sfr_wdata [2];

  always_comb begin
    sfr_raddr[0] = sfr_slot(byte_addr);
    sfr_raddr[1] = bit_slot;
    sfr_we[0]    = bit_wr && bit_in_sfr;
    sfr_waddr[0] = bit_slot;
    sfr_wdata[0] = put_bit(sfr_rdata[1], bit_pos, bit_wdata);
    sfr_we[1]    = byte_wr && byte_sfr_ok;
    sfr_waddr[1] = sfr_slot(byte_addr);
    sfr_wdata[1] = byte_wdata;
  end

  idm_ram #(.DEPTH(SFR_SLOTS), .NRD(2), .NWR(2)) u_sfr (
    .clk(clk), .rst_n(rst_n), .rd_addr(sfr_raddr), .rd_data(sfr_rdata),
    .wr_en(sfr_we), .wr_addr(sfr_waddr), .wr_data(sfr_wdata)
  );

  // read side
  always_comb begin
    if (byte_in_ram)      byte_rdata = ram_rdata[RP_BYTE];
    else if (byte_sfr_ok) byte_rdata = sfr_rdata[0];
    else                  byte_rdata = '0;
    reg_rdata = ram_rdata[RP_REG];
    bit_rdata = bit_in_sfr ? sfr_rdata[1][bit_pos] : ram_rdata[RP_BIT][bit_pos];
    stk_rdata = ram_rdata[RP_STK];
  end

  // named events for the checker
  logic bit_commit_ev, reg_commit_ev, byte_ram_wr_ev;
  assign byte_ram_wr_ev = byte_wr && byte_in_ram;
  assign reg_commit_ev  = reg_wr && !(byte_ram_wr_ev && byte_addr == reg_byte);
  assign bit_commit_ev  = bit_wr &&
      !(byte_wr && byte_addr == bit_byte) &&
      !(!bit_in_sfr && reg_wr && reg_byte == bit_byte) &&
      !(!bit_in_sfr && push_ev && push_addr == bit_byte);
endmodule

// File: rtl/idm_bank_mem_chk.sv
module idm_bank_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_sel,
  input logic [7:0] byte_addr,
  input logic [7:0] byte_wdata,
  input logic [7:0] byte_rdata,
  input logic [2:0] reg_idx,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] bit_addr,
  input logic       bit_wdata,
  input logic       bit_rdata,
  input logic       stk_push,
  input logic       stk_pop,
  input logic [7:0] sp_out,
  input logic       bit_commit_ev,
  input logic       reg_commit_ev,
  input logic       byte_ram_wr_ev
);
  // R1
  sp_reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> sp_out == 8'h07);

  // R8
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |=> sp_out == 8'($past(sp_out) + 8'd1));

  // R9
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && !stk_push) |=> sp_out == 8'($past(sp_out) - 8'd1));

  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_pop && !stk_push) |=> $stable(sp_out));

  // R6
  bit_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_commit_ev) && $stable(bit_addr)) |-> bit_rdata == $past(bit_wdata));

  // R7
  byte_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byte_ram_wr_ev) && $stable(byte_addr)) |-> byte_rdata == $past(byte_wdata));

  // R2
  reg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_commit_ev) && $stable(bank_sel) && $stable(reg_idx))
      |-> reg_rdata == $past(reg_wdata));
endmodule

bind idm_bank_mem idm_bank_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .byte_addr(byte_addr),
  .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_addr(bit_addr),
  .bit_wdata(bit_wdata), .bit_rdata(bit_rdata), .stk_push(stk_push),
  .stk_pop(stk_pop), .sp_out(sp_out), .bit_commit_ev(bit_commit_ev),
  .reg_commit_ev(reg_commit_ev), .byte_ram_wr_ev(byte_ram_wr_ev)
);

// File: tb/sim_idm_bank_mem.sv
`timescale 1ns/1ps
module sim_idm_bank_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic [7:0] byte_addr = '0;
  logic       byte_wr = 1'b0;
  logic [7:0] byte_wdata = '0;
  logic [7:0] byte_rdata;
  logic [2:0] reg_idx = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] bit_addr = '0;
  logic       bit_wr = 1'b0;
  logic       bit_wdata = 1'b0;
  logic       bit_rdata;
  logic       stk_push = 1'b0;
  logic       stk_pop = 1'b0;
  logic [7:0] stk_wdata = '0;
  logic [7:0] stk_rdata;
  logic [7:0] sp_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  idm_bank_mem u0 (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .byte_addr(byte_addr), .byte_wr(byte_wr), .byte_wdata(byte_wdata),
    .byte_rdata(byte_rdata), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_addr(bit_addr),
    .bit_wr(bit_wr), .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
    .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
    .stk_rdata(stk_rdata), .sp_out(sp_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // one clock edge, then release all strobes
  task automatic tick();
    @(posedge clk);
    #1;
    byte_wr = 0; reg_wr = 0; bit_wr = 0; stk_push = 0; stk_pop = 0;
    #1;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    byte_addr = a; byte_wdata = d; byte_wr = 1; tick();
  endtask

  task automatic rd_byte(input string tag, input logic [7:0] a, input logic [7:0] exp);
    byte_addr = a; #1;
    chk(tag, byte_rdata, exp);
  endtask

  task automatic wr_bit(input logic [7:0] k, input logic v);
    bit_addr = k; bit_wdata = v; bit_wr = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 sp after reset", sp_out, 8'h07);
    rd_byte("R1 ram byte 0x20", 8'h20, 8'h00);
    rd_byte("R1 ram byte 0x7F", 8'h7F, 8'h00);
    rd_byte("R1 sfr byte 0x80", 8'h80, 8'h00);
    bank_sel = 2'd3; reg_idx = 3'd7; #1;
    chk("R1 register r7 bank3", reg_rdata, 8'h00);
  endtask

  task automatic t_bank_alias();
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b); reg_idx = 3'd5; reg_wdata = 8'hA0 + 8'(b); reg_wr = 1; tick();
    end
    for (int b = 0; b < 4; b++)
      rd_byte("R2 reg->byte alias", 8'(8 * b + 5), 8'hA0 + 8'(b));
    wr_byte(8'h1A, 8'h5C);
    bank_sel = 2'd3; reg_idx = 3'd2; #1;
    chk("R2 byte->reg alias bank3 r2", reg_rdata, 8'h5C);
  endtask

  task automatic t_bank_switch();
    bank_sel = 2'd1; reg_idx = 3'd5; #1;
    chk("R3 read bank1 r5", reg_rdata, 8'hA1);
    bank_sel = 2'd2; #1;
    chk("R3 same-cycle switch to bank2", reg_rdata, 8'hA2);
    bank_sel = 2'd0; reg_idx = 3'd7; reg_wdata = 8'h77; reg_wr = 1; tick();
    bank_sel = 2'd3; reg_wdata = 8'h33; reg_wr = 1; tick();
    rd_byte("R3 write before switch at 0x07", 8'h07, 8'h77);
    rd_byte("R3 write after switch at 0x1F", 8'h1F, 8'h33);
  endtask

  task automatic t_bit_ram();
    wr_bit(8'h2B, 1'b1);
    rd_byte("R4 bit 0x2B sets 0x25 bit3", 8'h25, 8'h08);
    bit_addr = 8'h2A; #1;
    chk("R4 bit read 0x2A", 8'(bit_rdata), 8'h00);
    bit_addr = 8'h2B; #1;
    chk("R4 bit read 0x2B", 8'(bit_rdata), 8'h01);
    wr_bit(8'h00, 1'b1);
    rd_byte("R4 bit 0x00 sets 0x20 bit0", 8'h20, 8'h01);
    wr_byte(8'h2F, 8'hFF);
    wr_bit(8'h7F, 1'b0);
    rd_byte("R6 bit 0x7F clears only 0x2F bit7", 8'h2F, 8'h7F);
    wr_byte(8'h26, 8'hA5);
    wr_bit(8'h31, 1'b1);
    rd_byte("R6 bit 0x31 sets only 0x26 bit1", 8'h26, 8'hA7);
    wr_bit(8'h35, 1'b0);
    rd_byte("R6 bit 0x35 clears only 0x26 bit5", 8'h26, 8'h87);
  endtask

  task automatic t_bit_sfr();
    wr_bit(8'h94, 1'b1);
    rd_byte("R5 bit 0x94 sets sfr 0x90 bit4", 8'h90, 8'h10);
    wr_byte(8'hF8, 8'h3C);
    bit_addr = 8'hFA; #1;
    chk("R5 bit read 0xFA", 8'(bit_rdata), 8'h01);
    bit_addr = 8'hF8; #1;
    chk("R5 bit read 0xF8", 8'(bit_rdata), 8'h00);
    wr_bit(8'h8F, 1'b1);
    rd_byte("R5 bit 0x8F sets sfr 0x88 bit7", 8'h88, 8'h80);
    wr_byte(8'h80, 8'h11);
    wr_byte(8'h81, 8'hEE);
    rd_byte("R5 unheld 0x81 reads zero", 8'h81, 8'h00);
    rd_byte("R5 0x80 unaffected by 0x81 write", 8'h80, 8'h11);
  endtask

  task automatic t_conflict();
    byte_addr = 8'h27; byte_wdata = 8'h3C; byte_wr = 1;
    bit_addr = 8'h38; bit_wdata = 1'b1; bit_wr = 1; tick();
    rd_byte("R7 byte beats bit in RAM", 8'h27, 8'h3C);
    byte_addr = 8'h0B; byte_wdata = 8'h11; byte_wr = 1;
    bank_sel = 2'd1; reg_idx = 3'd3; reg_wdata = 8'h22; reg_wr = 1; tick();
    rd_byte("R7 byte beats register", 8'h0B, 8'h11);
    byte_addr = 8'hA0; byte_wdata = 8'h0F; byte_wr = 1;
    bit_addr = 8'hA7; bit_wdata = 1'b1; bit_wr = 1; tick();
    rd_byte("R7 byte beats bit in sfr", 8'hA0, 8'h0F);
    // sp is 0x07 here: push targets 0x08 = bank1 r0
    bank_sel = 2'd1; reg_idx = 3'd0; reg_wdata = 8'h44; reg_wr = 1;
    stk_wdata = 8'h99; stk_push = 1; tick();
    rd_byte("R7 register beats push", 8'h08, 8'h44);
    stk_pop = 1; tick();
    chk("R7 sp restored", sp_out, 8'h07);
  endtask

  task automatic t_push_pop();
    stk_wdata = 8'hAA; stk_push = 1; tick();
    chk("R8 sp after push", sp_out, 8'h08);
    rd_byte("R8 push data at new sp", 8'h08, 8'hAA);
    chk("R8 stack read at sp", stk_rdata, 8'hAA);
    stk_wdata = 8'hBB; stk_push = 1; tick();
    chk("R8 sp after second push", sp_out, 8'h09);
    chk("R9 top before pop", stk_rdata, 8'hBB);
    stk_pop = 1; tick();
    chk("R9 sp after pop", sp_out, 8'h08);
    chk("R9 new top after pop", stk_rdata, 8'hAA);
    stk_wdata = 8'hCC; stk_push = 1; stk_pop = 1; tick();
    chk("R9 push wins over pop", sp_out, 8'h09);
    rd_byte("R9 push data with pop", 8'h09, 8'hCC);
    stk_pop = 1; tick();
    stk_pop = 1; tick();
    chk("R9 back to reset sp", sp_out, 8'h07);
  endtask

  task automatic t_deep_stack();
    int bad;
    for (int i = 0; i < 248; i++) begin
      stk_wdata = 8'(i) ^ 8'h5A; stk_push = 1; tick();
    end
    chk("R10 sp after 248 pushes", sp_out, 8'hFF);
    rd_byte("R10 first push at 0x08", 8'h08, 8'h5A);
    rd_byte("R10 sfr 0x80 not aliased by stack", 8'h80, 8'h11);
    chk("R10 top at 0xFF", stk_rdata, 8'(247) ^ 8'h5A);
    bad = 0;
    for (int i = 247; i >= 0; i--) begin
      if (stk_rdata !== (8'(i) ^ 8'h5A)) bad++;
      stk_pop = 1; tick();
    end
    chk("R10 pop order mismatches", 8'(bad), 8'h00);
    chk("R10 sp after draining", sp_out, 8'h07);
    for (int i = 0; i < 248; i++) begin
      stk_wdata = 8'h00; stk_push = 1; tick();
    end
    stk_wdata = 8'hE1; stk_push = 1; tick();
    chk("R10 sp wraps to 0x00", sp_out, 8'h00);
    rd_byte("R10 wrapped push at 0x00", 8'h00, 8'hE1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_bank_alias();
    t_bank_switch();
    t_bit_ram();
    t_bit_sfr();
    t_conflict();
    t_push_pop();
    t_deep_stack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule